// File: doc/BRIEF.md
# Port Overcurrent and Disconnect Protection Timer

This block is the timing half of a powered-port protection channel. Analog comparators outside it report four digitised conditions: the sense current is above the overcurrent cutoff, the port is being held in current limit, the sense current has reached the short-circuit level, and the sense current has dropped below the disconnect minimum. From these flags the block decides when the external pass transistor must be switched off. It also decides which fault is recorded.

An overcurrent timer accumulates time spent over the cutoff and expires after a cutoff time chosen by a 2-bit code. The same accumulator drains slowly while the port is healthy, and this caps the long-run fraction of time spent in current limit near one sixteenth. A disconnect timer counts time with too little load current, against a delay chosen by a second 2-bit code. A minimum-pulse filter stops brief current bursts from restarting that timer. A short circuit bypasses all timing and requests a fast pull-down of the gate at once. Any recorded fault keeps the gate off until the sequencer drops and re-asserts the port enable. All time is measured in milliseconds derived from the clock by the parameter `CYC_PER_MS`.

Top module: `port_prot_timer`

## Requirements
- R1: While `port_en` is low, or while reset is asserted, `gate_kill` is 1, `fast_pd` is 0 and no event output pulses, whatever the comparator flags do.
- R2: The first clock edge that samples `port_en` high counts as edge 0. An overcurrent held from that edge raises `gate_kill` at edge ms×`CYC_PER_MS`. Here ms comes from `cut_sel`: 2'b00 = 60, 2'b01 = 30, 2'b10 = 120, 2'b11 = 240.
- R3: An overcurrent trip pulses `evt_start_oc` when `phase_start` is 1 at the trip edge, and `evt_run_oc` when it is 0. The pulse lasts one cycle and appears at the same edge where `gate_kill` rises.
- R4: `lim_flag` feeds the overcurrent timer in the same way as `oc_flag`.
- R5: On each millisecond tick the timer adds 15 while over the cutoff and subtracts 1 otherwise, saturating at zero. The trip level is 15×ms. A pattern of 1 ms over in every 16 ms never trips. A pattern of 2 ms over in every 16 ms does trip. A long healthy stretch leaves the timer at zero, not below it.
- R6: A `sc_flag` sampled high while the port is on raises `gate_kill` and `fast_pd` at that same edge, with no timer. It also pulses the overcurrent event of the current phase.
- R7: In the running phase, a `low_flag` held from edge 0 raises `gate_kill` and pulses `evt_disc` at edge ms×`CYC_PER_MS`. Here ms comes from `dis_sel`: 2'b00 = 360, 2'b01 = 90, 2'b10 = 180, 2'b11 = 720.
- R8: While `phase_start` is 1 the disconnect timer is held at zero. It counts only tick edges after `phase_start` has been sampled low.
- R9: If `low_flag` drops for fewer than `FILT_CYC` cycles, the disconnect count is held: the ticks inside the gap are skipped and the count is not cleared. A gap of `FILT_CYC` cycles or more clears the count.
- R10: After any trip, `gate_kill` stays 1 (and `fast_pd` stays 1 after a short) while `port_en` stays high. Lowering and re-raising `port_en` restarts all timers from zero.
- R11: At most one event pulses per trip. Short circuit has priority over overcurrent, and overcurrent has priority over disconnect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Port switched on by the sequencer; low re-arms the block |
| phase_start | input | 1 | 1 during start-up, 0 while running |
| oc_flag | input | 1 | Sense current above the overcurrent cutoff |
| lim_flag | input | 1 | Port held in current limit |
| sc_flag | input | 1 | Sense current at short-circuit level |
| low_flag | input | 1 | Sense current below the disconnect minimum |
| cut_sel | input | 2 | Overcurrent cutoff time code |
| dis_sel | input | 2 | Disconnect delay code |
| gate_kill | output | 1 | Gate must be off |
| fast_pd | output | 1 | Fast gate pull-down request after a short |
| evt_run_oc | output | 1 | One-cycle pulse: overcurrent trip while running |
| evt_start_oc | output | 1 | One-cycle pulse: overcurrent trip during start-up |
| evt_disc | output | 1 | One-cycle pulse: disconnect trip |

## Verification
Every timed result is tied to the tick grid: ticks fall on edges n×`CYC_PER_MS`−1 after the enabling edge, and the trip register adds one more edge. A timed trip is therefore due at edge ms×`CYC_PER_MS`, and a short at the very edge that samples it. The bench keeps an edge index from the enabling edge and samples half a cycle after each edge. It checks that the gate is still on at the edge before the due edge, that gate and event change exactly at the due edge, and that the pulse is gone one edge later. Where gaps or phase changes shift the grid, the due edge is derived arithmetically from the first counted tick after the gap.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

  localparam int unsigned CUT_MS_MAX = 240;
  localparam int unsigned DIS_MS_MAX = 720;

  typedef enum logic [1:0] {
    TRIP_NONE  = 2'd0,
    TRIP_SHORT = 2'd1,
    TRIP_OVER  = 2'd2,
    TRIP_DISC  = 2'd3
  } trip_e;

  // overcurrent cutoff in milliseconds per selection code
  function automatic int unsigned cut_ms(input logic [1:0] code);
    case (code)
      2'b00:   return 60;
      2'b01:   return 30;
      2'b10:   return 120;
      default: return 240;
    endcase
  endfunction

  // disconnect delay in milliseconds per selection code
  function automatic int unsigned dis_ms(input logic [1:0] code);
    case (code)
      2'b00:   return 360;
      2'b01:   return 90;
      2'b10:   return 180;
      default: return 720;
    endcase
  endfunction

endpackage

// File: rtl/ptmr_tick.sv
module ptmr_tick #(
  parameter int unsigned CYC_PER_MS = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  generate
    if (CYC_PER_MS <= 1) begin : g_every
      assign tick = run;
    end else begin : g_div
      localparam int unsigned CW = $clog2(CYC_PER_MS);
      localparam logic [CW-1:0] LAST = CW'(CYC_PER_MS - 1);

      logic [CW-1:0] cnt_q;
      logic [CW-1:0] cnt_d;
      logic          at_last;

      assign at_last = (cnt_q == LAST);

      always_comb begin
        if (!run || at_last) cnt_d = '0;
        else                 cnt_d = cnt_q + CW'(1);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      assign tick = run && at_last;
    end
  endgenerate

endmodule

// File: rtl/ptmr_fault_acc.sv
module ptmr_fault_acc #(
  parameter int unsigned ACC_W   = 12,
  parameter int unsigned UP_STEP = 15,
  parameter int unsigned DN_STEP = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             over,
  input  logic [ACC_W-1:0] limit,
  output logic             expired
);

  localparam logic [ACC_W-1:0] UP  = ACC_W'(UP_STEP);
  localparam logic [ACC_W-1:0] DN  = ACC_W'(DN_STEP);
  localparam logic [ACC_W-1:0] TOP = '1;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_d;
  logic             acc_en;

  assign acc_en = !run || tick;

  always_comb begin
    acc_d = acc_q;
    if (!run) begin
      acc_d = '0;
    end else if (over) begin
      acc_d = (acc_q > (TOP - UP)) ? TOP : (acc_q + UP);
    end else begin
      acc_d = (acc_q > DN) ? (acc_q - DN) : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  assign expired = run && (acc_q >= limit);

endmodule

// File: rtl/ptmr_disc.sv
module ptmr_disc #(
  parameter int unsigned DCNT_W   = 10,
  parameter int unsigned FILT_CYC = 250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick,
  input  logic              low,
  input  logic [DCNT_W-1:0] limit,
  output logic              expired
);

  localparam int unsigned FILT_W = $clog2(FILT_CYC + 1);
  localparam logic [FILT_W-1:0] FILT_LIM = FILT_W'(FILT_CYC);

  logic [FILT_W-1:0] hi_q;
  logic [FILT_W-1:0] hi_d;
  logic              hi_full;
  logic [DCNT_W-1:0] dcnt_q;
  logic [DCNT_W-1:0] dcnt_d;
  logic              dcnt_en;
  logic              dcnt_clr;

  // length of the current gap in the low-current condition
  assign hi_full = (hi_q >= FILT_LIM);

  always_comb begin
    if (low)          hi_d = '0;
    else if (hi_full) hi_d = hi_q;
    else              hi_d = hi_q + FILT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_q <= '0;
    else        hi_q <= hi_d;
  end

  // disconnect count: cleared by a long gap, held by a short one
  assign dcnt_clr = !run || hi_full;
  assign dcnt_en  = dcnt_clr || (tick && low);

  always_comb begin
    if (dcnt_clr)            dcnt_d = '0;
    else if (dcnt_q == '1)   dcnt_d = dcnt_q;
    else                     dcnt_d = dcnt_q + DCNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dcnt_q <= '0;
    else if (dcnt_en) dcnt_q <= dcnt_d;
  end

  assign expired = run && (dcnt_q >= limit);

endmodule

// File: rtl/port_prot_timer.sv
module port_prot_timer
  import ptmr_pkg::*;
#(
  parameter int unsigned CYC_PER_MS = 250000,
  parameter int unsigned UP_STEP    = 15,
  parameter int unsigned DN_STEP    = 1,
  parameter int unsigned FILT_CYC   = 250000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       port_en,
  input  logic       phase_start,
  input  logic       oc_flag,
  input  logic       lim_flag,
  input  logic       sc_flag,
  input  logic       low_flag,
  input  logic [1:0] cut_sel,
  input  logic [1:0] dis_sel,
  output logic       gate_kill,
  output logic       fast_pd,
  output logic       evt_run_oc,
  output logic       evt_start_oc,
  output logic       evt_disc
);

  localparam int unsigned ACC_MAX = CUT_MS_MAX * UP_STEP;
  localparam int unsigned ACC_W   = $clog2(ACC_MAX + UP_STEP + 1);
  localparam int unsigned DCNT_W  = $clog2(DIS_MS_MAX + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_in_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end

  assign rst_in_n = rsync_q[1];

  logic              off_q, off_d;
  logic              sc_q, sc_d;
  logic              ev_run_q, ev_run_d;
  logic              ev_start_q, ev_start_d;
  logic              ev_disc_q, ev_disc_d;
  logic              active;
  logic              tick;
  logic              oc_exp;
  logic              dis_exp;
  logic [ACC_W-1:0]  cut_lim;
  logic [DCNT_W-1:0] dis_lim;
  trip_e             trip;

  assign active  = port_en && !off_q;
  assign cut_lim = ACC_W'(cut_ms(cut_sel) * UP_STEP);
  assign dis_lim = DCNT_W'(dis_ms(dis_sel));

  ptmr_tick #(
    .CYC_PER_MS(CYC_PER_MS)
  ) u_tick (
    .clk  (clk),
    .rst_n(rst_in_n),
    .run  (port_en),
    .tick (tick)
  );

  ptmr_fault_acc #(
    .ACC_W  (ACC_W),
    .UP_STEP(UP_STEP),
    .DN_STEP(DN_STEP)
  ) u_acc (
    .clk    (clk),
    .rst_n  (rst_in_n),
    .run    (active),
    .tick   (tick),
    .over   (oc_flag || lim_flag),
    .limit  (cut_lim),
    .expired(oc_exp)
  );

  ptmr_disc #(
    .DCNT_W  (DCNT_W),
    .FILT_CYC(FILT_CYC)
  ) u_disc (
    .clk    (clk),
    .rst_n  (rst_in_n),
    .run    (active && !phase_start),
    .tick   (tick),
    .low    (low_flag),
    .limit  (dis_lim),
    .expired(dis_exp)
  );

  // trip arbitration: short, then overcurrent, then disconnect
  always_comb begin
    trip = TRIP_NONE;
    if (active) begin
      if (sc_flag)      trip = TRIP_SHORT;
      else if (oc_exp)  trip = TRIP_OVER;
      else if (dis_exp) trip = TRIP_DISC;
    end
  end

  always_comb begin
    off_d      = port_en && (off_q || (trip != TRIP_NONE));
    sc_d       = port_en && (sc_q || (trip == TRIP_SHORT));
    ev_start_d = ((trip == TRIP_SHORT) || (trip == TRIP_OVER)) && phase_start;
    ev_run_d   = ((trip == TRIP_SHORT) || (trip == TRIP_OVER)) && !phase_start;
    ev_disc_d  = (trip == TRIP_DISC);
  end

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) begin
      off_q      <= 1'b0;
      sc_q       <= 1'b0;
      ev_run_q   <= 1'b0;
      ev_start_q <= 1'b0;
      ev_disc_q  <= 1'b0;
    end else begin
      off_q      <= off_d;
      sc_q       <= sc_d;
      ev_run_q   <= ev_run_d;
      ev_start_q <= ev_start_d;
      ev_disc_q  <= ev_disc_d;
    end
  end

  assign gate_kill    = !rst_in_n || !port_en || off_q;
  assign fast_pd      = sc_q;
  assign evt_run_oc   = ev_run_q;
  assign evt_start_oc = ev_start_q;
  assign evt_disc     = ev_disc_q;

endmodule

// File: rtl/ptmr_chk.sv
module ptmr_chk (
  input logic clk,
  input logic rst_n,
  input logic port_en,
  input logic phase_start,
  input logic sc_flag,
  input logic gate_kill,
  input logic fast_pd,
  input logic evt_run_oc,
  input logic evt_start_oc,
  input logic evt_disc
);

  logic any_evt;
  assign any_evt = evt_run_oc || evt_start_oc || evt_disc;

  a_r11_single_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt_run_oc, evt_start_oc, evt_disc}));

  a_r1_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> (!any_evt && !fast_pd));

  a_r3_event_at_trip: assert property (@(posedge clk) disable iff (!rst_n)
    any_evt |-> (gate_kill && !$past(gate_kill)));

  a_r3_start_phase: assert property (@(posedge clk) disable iff (!rst_n)
    evt_start_oc |-> $past(phase_start));

  a_r3_run_phase: assert property (@(posedge clk) disable iff (!rst_n)
    evt_run_oc |-> !$past(phase_start));

  a_r6_short_immediate: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && !gate_kill && sc_flag) |=> (fast_pd || !port_en));

  a_r6_pulldown_kills: assert property (@(posedge clk) disable iff (!rst_n)
    fast_pd |-> gate_kill);

  a_r10_trip_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && gate_kill) |=> (gate_kill || !port_en));

endmodule

bind port_prot_timer ptmr_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .port_en     (port_en),
  .phase_start (phase_start),
  .sc_flag     (sc_flag),
  .gate_kill   (gate_kill),
  .fast_pd     (fast_pd),
  .evt_run_oc  (evt_run_oc),
  .evt_start_oc(evt_start_oc),
  .evt_disc    (evt_disc)
);

// File: tb/sim_port_prot_timer.sv
module sim_port_prot_timer;

  localparam int CYC  = 4;
  localparam int FILT = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       port_en, phase_start, oc_flag, lim_flag, sc_flag, low_flag;
  logic [1:0] cut_sel, dis_sel;
  logic       gate_kill, fast_pd, evt_run_oc, evt_start_oc, evt_disc;

  int  checks = 0;
  int  errors = 0;
  int  e      = 0;
  bit  done   = 0;

  always #2 clk = ~clk;

  port_prot_timer #(
    .CYC_PER_MS(CYC),
    .UP_STEP   (15),
    .DN_STEP   (1),
    .FILT_CYC  (FILT)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .phase_start(phase_start),
    .oc_flag(oc_flag), .lim_flag(lim_flag), .sc_flag(sc_flag), .low_flag(low_flag),
    .cut_sel(cut_sel), .dis_sel(dis_sel), .gate_kill(gate_kill), .fast_pd(fast_pd),
    .evt_run_oc(evt_run_oc), .evt_start_oc(evt_start_oc), .evt_disc(evt_disc)
  );

  function automatic int exp_cut(input logic [1:0] c);
    case (c) 2'b00: return 60; 2'b01: return 30; 2'b10: return 120; default: return 240; endcase
  endfunction

  function automatic int exp_dis(input logic [1:0] c);
    case (c) 2'b00: return 360; 2'b01: return 90; 2'b10: return 180; default: return 720; endcase
  endfunction

  function automatic bit oc_at(input int kind, input int on, input int period, input int ms);
    if (kind == 0) return (ms % period) < on;
    return (ms < 20) || (ms >= 420);
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    e++;
  endtask

  task automatic goto_edge(input int x);
    while (e < x) step();
  endtask

  task automatic start_port(input bit ph, input logic [1:0] c, input logic [1:0] d,
                            input bit oc, input bit lim, input bit low);
    phase_start = ph; cut_sel = c; dis_sel = d;
    oc_flag = oc; lim_flag = lim; low_flag = low; sc_flag = 1'b0;
    port_en = 1'b1;
    e = -1;
    step();
  endtask

  task automatic stop_port();
    port_en = 1'b0; oc_flag = 0; lim_flag = 0; low_flag = 0; sc_flag = 0; phase_start = 0;
    step();
    chk(gate_kill && !fast_pd, "R10", "disable clears", {gate_kill, fast_pd}, 2'b10);
    step(); step();
  endtask

  task automatic expect_trip(input int k, input bit es, input bit er, input bit ed,
                             input bit fp, input string req);
    bit early = 0;
    while (e < k - 1) begin
      step();
      if (gate_kill || evt_run_oc || evt_start_oc || evt_disc) early = 1;
    end
    if (gate_kill) early = 1;
    chk(!early, req, "gate still on before due edge", early, 0);
    step();
    chk(gate_kill, req, "gate_kill at due edge", gate_kill, 1);
    chk({evt_start_oc, evt_run_oc, evt_disc} == {es, er, ed}, req, "event pulse",
        {evt_start_oc, evt_run_oc, evt_disc}, {es, er, ed});
    chk(fast_pd == fp, req, "fast_pd", fast_pd, fp);
    step();
    chk(!(evt_start_oc || evt_run_oc || evt_disc), req, "event lasts one cycle",
        {evt_start_oc, evt_run_oc, evt_disc}, 0);
  endtask

  task automatic run_pattern(input int kind, input int on, input int period,
                             input int until_edge, output bit early);
    early = 0;
    while (e < until_edge) begin
      oc_flag = oc_at(kind, on, period, (e + 1) / CYC);
      step();
      if (gate_kill || evt_run_oc || evt_start_oc || evt_disc) early = 1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit bad;
    rst_n = 0; port_en = 0; phase_start = 0; oc_flag = 0; lim_flag = 0;
    sc_flag = 0; low_flag = 0; cut_sel = 0; dis_sel = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(gate_kill && !fast_pd && !evt_run_oc && !evt_start_oc && !evt_disc,
        "R1", "reset state", {gate_kill, fast_pd}, 2'b10);
    rst_n = 1;
    // R1: port disabled, all flags active, nothing happens
    oc_flag = 1; sc_flag = 1; low_flag = 1;
    bad = 0;
    repeat (60) begin
      step();
      if (!gate_kill || fast_pd || evt_run_oc || evt_start_oc || evt_disc) bad = 1;
    end
    chk(!bad, "R1", "disabled port ignores flags", bad, 0);
    oc_flag = 0; sc_flag = 0; low_flag = 0;
    step();

    // R2 and R3: every cutoff code in both phases
    for (int ph = 0; ph < 2; ph++) begin
      for (int c = 0; c < 4; c++) begin
        start_port(ph[0], c[1:0], 2'b00, 1'b1, 1'b0, 1'b0);
        expect_trip(exp_cut(c[1:0]) * CYC, ph[0], !ph[0], 1'b0, 1'b0, ph ? "R3" : "R2");
        stop_port();
      end
    end

    // R4: current-limit flag alone, 60 ms code
    start_port(1'b0, 2'b00, 2'b00, 1'b0, 1'b1, 1'b0);
    expect_trip(60 * CYC, 1'b0, 1'b1, 1'b0, 1'b0, "R4");
    stop_port();

    // R5: 1 ms in 16 balances exactly (+15, -15) and never trips
    start_port(1'b0, 2'b01, 2'b00, 1'b1, 1'b0, 1'b0);
    run_pattern(0, 1, 16, 640 * CYC, bad);
    chk(!bad && !gate_kill, "R5", "1/16 duty never trips", bad, 0);
    stop_port();

    // R5: 2 ms in 16 nets +16 per period; period 27 peaks at 432+30 >= 450, ms 433
    start_port(1'b0, 2'b01, 2'b00, 1'b1, 1'b0, 1'b0);
    run_pattern(0, 2, 16, 434 * CYC - 1, bad);
    chk(!bad, "R5", "2/16 duty no early trip", bad, 0);
    expect_trip(434 * CYC, 1'b0, 1'b1, 1'b0, 1'b0, "R5");
    stop_port();

    // R5: 300 up, 400 down saturates at zero, then full 30 ms again
    start_port(1'b0, 2'b01, 2'b00, 1'b1, 1'b0, 1'b0);
    run_pattern(1, 0, 1, 450 * CYC - 1, bad);
    chk(!bad, "R5", "saturation no early trip", bad, 0);
    expect_trip(450 * CYC, 1'b0, 1'b1, 1'b0, 1'b0, "R5");
    stop_port();

    // R6: short in each phase, then R10 hold check
    for (int ph = 0; ph < 2; ph++) begin
      start_port(ph[0], 2'b11, 2'b00, 1'b0, 1'b0, 1'b0);
      goto_edge(19);
      sc_flag = 1;
      expect_trip(20, ph[0], !ph[0], 1'b0, 1'b1, "R6");
      sc_flag = 0; oc_flag = 1; low_flag = 1;
      bad = 0;
      repeat (40) begin
        step();
        if (!gate_kill || !fast_pd || evt_run_oc || evt_start_oc || evt_disc) bad = 1;
      end
      chk(!bad, "R10", "trip latched while enabled", bad, 0);
      stop_port();
    end

    // R10: re-enable restarts the timer from zero
    start_port(1'b0, 2'b01, 2'b00, 1'b1, 1'b0, 1'b0);
    expect_trip(30 * CYC, 1'b0, 1'b1, 1'b0, 1'b0, "R10");
    stop_port();

    // R7: every disconnect code
    for (int d = 0; d < 4; d++) begin
      start_port(1'b0, 2'b11, d[1:0], 1'b0, 1'b0, 1'b1);
      expect_trip(exp_dis(d[1:0]) * CYC, 1'b0, 1'b0, 1'b1, 1'b0, "R7");
      stop_port();
    end

    // R8: start-up phase holds the disconnect timer; counting from edge 800
    start_port(1'b1, 2'b11, 2'b01, 1'b0, 1'b0, 1'b1);
    goto_edge(799);
    chk(!gate_kill, "R8", "no disconnect in start-up", gate_kill, 0);
    phase_start = 0;
    // first counted tick 803, 90th at 803 + 89*4 = 1159
    expect_trip(1160, 1'b0, 1'b0, 1'b1, 1'b0, "R8");
    stop_port();

    // R9: 3-cycle gap over tick edge 43 skips one tick only
    start_port(1'b0, 2'b11, 2'b01, 1'b0, 1'b0, 1'b1);
    goto_edge(41);
    low_flag = 0;
    goto_edge(44);
    low_flag = 1;
    expect_trip(91 * CYC, 1'b0, 1'b0, 1'b1, 1'b0, "R9");
    stop_port();

    // R9: 8-cycle gap (edges 40..47) clears; low again at 48, first tick 51
    start_port(1'b0, 2'b11, 2'b01, 1'b0, 1'b0, 1'b1);
    goto_edge(39);
    low_flag = 0;
    goto_edge(47);
    low_flag = 1;
    expect_trip(51 + 89 * CYC + 1, 1'b0, 1'b0, 1'b1, 1'b0, "R9");
    stop_port();

    // R11: short and overcurrent expiry on the same edge
    start_port(1'b0, 2'b01, 2'b00, 1'b1, 1'b0, 1'b0);
    goto_edge(30 * CYC - 1);
    sc_flag = 1;
    expect_trip(30 * CYC, 1'b0, 1'b1, 1'b0, 1'b1, "R11");
    stop_port();

    // R11: overcurrent from ms 60 (30 ms) and disconnect (90 ms) expire together
    start_port(1'b0, 2'b01, 2'b01, 1'b0, 1'b0, 1'b1);
    goto_edge(60 * CYC - 1);
    oc_flag = 1;
    expect_trip(90 * CYC, 1'b0, 1'b1, 1'b0, 1'b0, "R11");
    stop_port();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule